// File: doc/BRIEF.md
# Serial EEPROM Bus Master Sequencer

This block is a two-wire serial-bus master that reads and writes a byte-addressed EEPROM. It drives the clock line directly and pulls the data line low through an output enable, so it never drives the data line high. It reads the line back through `sda_i`. Each bit period is cut into four quarters of `cfg_qdiv + 1` system clocks. The data line moves only in a quarter where the clock is low, and the slave's bit is sampled at the centre of the high time.

Three transactions share one engine. The first is a one-byte write and the second is a one-byte random read, both launched by `cmd_start`. The third is a sequential read of `cfg_burst_len` bytes that runs by itself once reset is released, and each received byte comes out on `rd_data` with a one-cycle `rd_valid`. When `cfg_skip_word` is set, every transaction leaves out the word-address byte and its acknowledge, so the device's own address pointer is used. A missing slave acknowledge ends the transaction with a stop and sets a sticky error flag.

The controller states are `S_IDLE`, `S_START`, `S_DEVW`, `S_WORD`, `S_WDATA`, `S_RSTART`, `S_DEVR`, `S_RDATA` and `S_STOP`. All transitions except the launch from `S_IDLE` happen when the current bus symbol completes:
- `S_IDLE` goes to `S_START` on the pending boot download or on `cmd_start`.
- `S_START` goes to `S_DEVW`, and `S_RSTART` goes to `S_DEVR`.
- `S_DEVW` goes to `S_WORD` when the slave acknowledges. When the word byte is skipped, it goes to `S_WDATA` for a write or to `S_RSTART` for a read.
- `S_WORD` goes to `S_WDATA` for a write or to `S_RSTART` for a read.
- `S_WDATA` goes to `S_STOP`, and `S_DEVR` goes to `S_RDATA`.
- `S_RDATA` loops on itself until its last byte and then goes to `S_STOP`.
- Any byte the slave leaves unacknowledged goes to `S_STOP`.
- `S_STOP` goes to `S_IDLE`.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: While in reset and whenever `busy` is low, `scl_o` is 1 and `sda_oe_o` is 0, so the data line is released.
- R2: `sda_oe_o` never changes in the same cycle as `scl_o`. Each clock-high time inside a transaction lasts exactly 2*(`cfg_qdiv`+1) system clocks.
- R3: A transaction opens with a start (data falls while the clock is high) and closes with a stop (data rises while the clock is high). A read adds one repeated start before the device address with the R/W bit set to 1.
- R4: After reset is released, `busy` rises without any command. The block then reads `cfg_burst_len` bytes (0 counts as 1) from word address `cfg_word_addr` and presents them in address order, one `rd_valid` pulse per byte.
- R5: In a read, the master acknowledges (pulls data low in the ninth clock) every byte except the last one. It leaves the last byte unacknowledged and then issues a stop.
- R6: `cmd_start` with `cmd_read`=0 sends these bytes MSB first: the device address with R/W bit 0 in bit 0, then `cfg_word_addr`, then `cfg_wr_data`. The slave stores the data at that word address, and no `rd_valid` occurs.
- R7: `cmd_start` with `cmd_read`=1 returns exactly one byte from `cfg_word_addr` on `rd_data` and leaves that byte unacknowledged.
- R8: With `cfg_skip_word`=1, the word-address byte is not sent. A write then transfers two bytes (address, data), and a read sends two address bytes around the repeated start. The slave's current pointer selects the location.
- R9: If the slave does not acknowledge a byte, `err` is set, the remaining bytes are dropped, a stop is issued and `busy` falls.
- R10: `err` stays set until `err_clr` is pulsed. Successful transactions do not clear it.
- R11: A `cmd_start` while `busy` is high is ignored and starts no further transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release triggers the boot download |
| cfg_qdiv | input | DIV_W | Quarter-period length minus one, in system clocks |
| cfg_dev_addr | input | 7 | Slave device address |
| cfg_word_addr | input | 8 | EEPROM word address |
| cfg_wr_data | input | 8 | Byte for a single write |
| cfg_burst_len | input | LEN_W | Byte count of the boot download |
| cfg_skip_word | input | 1 | 1 omits the word-address phase |
| cmd_start | input | 1 | One-cycle launch of a single-byte operation |
| cmd_read | input | 1 | 1 = single read, 0 = single write |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | High while a transaction runs |
| err | output | 1 | Sticky missing-acknowledge flag |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Data line read back |

## Verification
The assertions check three rules on every cycle: the bus is released whenever the block is idle, the data enable never moves on the same edge as the clock, and the error flag only rises during a transaction and then holds until cleared. The byte-level sequences cannot be seen from one cycle: the order of address, word and data bytes, the repeated start, the acknowledge on all but the last read byte, and the skipped word phase. Only the bench's EEPROM model can show these, by counting starts, stops, received bytes and master acknowledges per scenario. The same model shows memory contents and data order, as well as the ignored command during a busy transaction.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        SYM_START,
        SYM_STOP,
        SYM_BIT
    } sym_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEVW,
        S_WORD,
        S_WDATA,
        S_RSTART,
        S_DEVR,
        S_RDATA,
        S_STOP
    } state_e;

    // Line levels for one quarter of a symbol: {scl, sda pull-down}.
    function automatic logic [1:0] sym_drive(sym_e s, logic [1:0] q, logic b);
        logic [1:0] r;
        unique case (s)
            SYM_START: r = {(q == 2'd1) || (q == 2'd2), q[1]};
            SYM_STOP:  r = {q != 2'd0, q[1] == 1'b0};
            default:   r = {(q == 2'd1) || (q == 2'd2), ~b};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!en || tick)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_sym_engine.sv
module i2c_sym_engine
    import i2c_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             go,
    input  sym_e             sym_i,
    input  logic             bit_i,
    input  logic             sda_i,
    output logic             done_o,
    output logic             rx_bit_o,
    output logic             scl_o,
    output logic             sda_oe_o
);
    logic       active;
    logic [1:0] q;
    sym_e       sym_r;
    logic       bit_r;
    logic       tick;

    i2c_quarter_timer #(.DIV_W(DIV_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .div   (div),
        .tick  (tick)
    );

    assign done_o = active && tick && (q == 2'd3);

    // Symbol sequencing: latch the request, step the quarters, sample mid-high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            q        <= 2'd0;
            sym_r    <= SYM_STOP;
            bit_r    <= 1'b1;
            rx_bit_o <= 1'b1;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                q      <= 2'd0;
                sym_r  <= sym_i;
                bit_r  <= bit_i;
            end
        end else if (tick) begin
            q <= q + 2'd1;
            if (q == 2'd1) rx_bit_o <= sda_i;
            if (q == 2'd3) active   <= 1'b0;
        end
    end

    // Registered line drive, held between symbols.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o    <= 1'b1;
            sda_oe_o <= 1'b0;
        end else if (active) begin
            {scl_o, sda_oe_o} <= sym_drive(sym_r, q, bit_r);
        end
    end
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
    import i2c_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_qdiv,
    input  logic [6:0]       cfg_dev_addr,
    input  logic [7:0]       cfg_word_addr,
    input  logic [7:0]       cfg_wr_data,
    input  logic [LEN_W-1:0] cfg_burst_len,
    input  logic             cfg_skip_word,
    input  logic             cmd_start,
    input  logic             cmd_read,
    input  logic             err_clr,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             err,
    output logic             scl_o,
    output logic             sda_oe_o,
    input  logic             sda_i
);
    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = $clog2(BYTE_W + 1);
    localparam logic [BCNT_W-1:0] ACK_SLOT = BCNT_W'(BYTE_W);

    state_e             state, state_n;
    logic               boot_pend;
    logic               op_rd, op_skip;
    logic [6:0]         dev_r;
    logic [7:0]         word_r, wdata_r;
    logic [LEN_W-1:0]   remaining;
    logic [BYTE_W-1:0]  sh;
    logic [BCNT_W-1:0]  bit_cnt;
    sym_e               sym;
    logic               sym_bit, sym_done, rx_bit;
    logic               is_tx, at_ack, last_byte, launch;

    assign is_tx     = (state == S_DEVW) || (state == S_WORD) ||
                       (state == S_WDATA) || (state == S_DEVR);
    assign at_ack    = (bit_cnt == ACK_SLOT);
    assign last_byte = (remaining == LEN_W'(1));
    assign launch    = (state == S_IDLE) && (boot_pend || cmd_start);
    assign busy      = (state != S_IDLE);

    i2c_sym_engine #(.DIV_W(DIV_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (cfg_qdiv),
        .go       (busy),
        .sym_i    (sym),
        .bit_i    (sym_bit),
        .sda_i    (sda_i),
        .done_o   (sym_done),
        .rx_bit_o (rx_bit),
        .scl_o    (scl_o),
        .sda_oe_o (sda_oe_o)
    );

    // Symbol request for the current state.
    always_comb begin
        sym     = SYM_BIT;
        sym_bit = 1'b1;
        unique case (state)
            S_START, S_RSTART: sym = SYM_START;
            S_STOP:            sym = SYM_STOP;
            S_RDATA:           sym_bit = at_ack ? last_byte : 1'b1;
            default:           sym_bit = at_ack ? 1'b1 : sh[BYTE_W-1];
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (launch) state_n = S_START;
            S_START:  if (sym_done) state_n = S_DEVW;
            S_RSTART: if (sym_done) state_n = S_DEVR;
            S_DEVW, S_WORD, S_WDATA, S_DEVR: begin
                if (sym_done && at_ack) begin
                    if (rx_bit) state_n = S_STOP;
                    else begin
                        unique case (state)
                            S_DEVW:  state_n = !op_skip ? S_WORD : (op_rd ? S_RSTART : S_WDATA);
                            S_WORD:  state_n = op_rd ? S_RSTART : S_WDATA;
                            S_WDATA: state_n = S_STOP;
                            default: state_n = S_RDATA;
                        endcase
                    end
                end
            end
            S_RDATA:  if (sym_done && at_ack && last_byte) state_n = S_STOP;
            S_STOP:   if (sym_done) state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_pend <= 1'b1;
            op_rd     <= 1'b0;
            op_skip   <= 1'b0;
            dev_r     <= '0;
            word_r    <= '0;
            wdata_r   <= '0;
            remaining <= '0;
            sh        <= '0;
            bit_cnt   <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            err       <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (err_clr) err <= 1'b0;
            if (launch) begin
                boot_pend <= 1'b0;
                op_rd     <= boot_pend || cmd_read;
                op_skip   <= cfg_skip_word;
                dev_r     <= cfg_dev_addr;
                word_r    <= cfg_word_addr;
                wdata_r   <= cfg_wr_data;
                remaining <= (!boot_pend || cfg_burst_len == '0) ? LEN_W'(1) : cfg_burst_len;
            end else if (sym_done) begin
                if (state == S_START || state == S_RSTART) begin
                    sh      <= {dev_r, state == S_RSTART};
                    bit_cnt <= '0;
                end else if (is_tx) begin
                    if (!at_ack) begin
                        sh      <= {sh[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        bit_cnt <= '0;
                        if (rx_bit) err <= 1'b1;
                        sh <= (state_n == S_WORD) ? word_r : wdata_r;
                    end
                end else if (state == S_RDATA) begin
                    if (!at_ack) begin
                        sh      <= {sh[BYTE_W-2:0], rx_bit};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        rd_data   <= sh;
                        rd_valid  <= 1'b1;
                        remaining <= remaining - 1'b1;
                        bit_cnt   <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_eeprom_seq_chk.sv
module i2c_eeprom_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_oe_o,
    input logic busy,
    input logic err,
    input logic err_clr,
    input logic rd_valid
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && !sda_oe_o));

    assert_sda_not_on_scl_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $stable(scl_o));

    assert_rd_valid_in_txn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    assert_rd_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_err_raised_in_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

bind i2c_eeprom_seq i2c_eeprom_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o),
    .busy     (busy),
    .err      (err),
    .err_clr  (err_clr),
    .rd_valid (rd_valid)
);

// File: tb/i2c_eeprom_seq_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_seq_tb_top;
    localparam int DIV_W = 8;
    localparam int LEN_W = 8;
    localparam logic [6:0] SLV = 7'h50;
    localparam int HI_LEN = 4; // 2*(cfg_qdiv+1) with cfg_qdiv = 1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_qdiv = 8'd1;
    logic [6:0] cfg_dev_addr = SLV;
    logic [7:0] cfg_word_addr = 8'h10;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [LEN_W-1:0] cfg_burst_len = 8'd4;
    logic cfg_skip_word = 1'b0;
    logic cmd_start = 1'b0, cmd_read = 1'b0, err_clr = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid, busy, err, scl_o, sda_oe_o;
    logic slv_oe = 1'b0;
    logic sda_bus;

    assign sda_bus = !(sda_oe_o || slv_oe);

    always #5 clk = ~clk;

    i2c_eeprom_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_qdiv(cfg_qdiv), .cfg_dev_addr(cfg_dev_addr),
        .cfg_word_addr(cfg_word_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_burst_len(cfg_burst_len), .cfg_skip_word(cfg_skip_word),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .err_clr(err_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .err(err),
        .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_bus)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // EEPROM slave model and bus monitor
    logic [7:0] mem [256];
    logic [7:0] ptr = 8'h00, rx_sh = 8'h00, tx_sh = 8'h00;
    logic slv_skip = 1'b0;
    int bit_i = 0, byte_i = 0, hi_len = 0;
    bit s_act = 0, ackph = 0, tx = 0, rw = 0, m_ack = 0, in_txn = 0;
    logic ps = 1'b1, pd = 1'b1;
    int starts = 0, stops = 0, bytes_rx = 0, m_acks = 0, m_nacks = 0, hi_viol = 0;
    logic [7:0] rd_buf [16];
    int rd_n = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            s_act = 0; ackph = 0; tx = 0; slv_oe = 1'b0; in_txn = 0;
            ps = 1'b1; pd = 1'b1;
        end else begin
            if (rd_valid) begin
                if (rd_n < 16) rd_buf[rd_n] = rd_data;
                rd_n++;
            end
            if (scl_o) hi_len = ps ? hi_len + 1 : 1;
            if (scl_o && ps && pd && !sda_bus) begin
                starts++; s_act = 1; in_txn = 1; bit_i = 0; byte_i = 0;
                ackph = 0; tx = 0; slv_oe = 1'b0;
            end else if (scl_o && ps && !pd && sda_bus) begin
                stops++; s_act = 0; in_txn = 0; slv_oe = 1'b0;
            end else if (scl_o && !ps && s_act) begin
                if (ackph) begin
                    if (tx) begin
                        m_ack = !sda_bus;
                        if (m_ack) m_acks++; else m_nacks++;
                    end
                end else if (bit_i < 8) begin
                    if (!tx) rx_sh = {rx_sh[6:0], sda_bus};
                    bit_i++;
                end
            end else if (!scl_o && ps) begin
                if (in_txn && hi_len != HI_LEN) hi_viol++;
                if (s_act) begin
                    if (ackph) begin
                        ackph = 0; bit_i = 0;
                        if (tx) begin
                            if (m_ack) begin tx_sh = mem[ptr]; ptr++; slv_oe = !tx_sh[7]; end
                            else begin slv_oe = 1'b0; s_act = 0; end
                        end else if (byte_i == 0 && rw) begin
                            tx = 1; tx_sh = mem[ptr]; ptr++; slv_oe = !tx_sh[7];
                        end else slv_oe = 1'b0;
                        byte_i++;
                    end else if (bit_i == 8) begin
                        ackph = 1;
                        if (tx) slv_oe = 1'b0;
                        else begin
                            bytes_rx++;
                            if (byte_i == 0) begin
                                if (rx_sh[7:1] == SLV) begin slv_oe = 1'b1; rw = rx_sh[0]; end
                                else begin slv_oe = 1'b0; s_act = 0; end
                            end else if (byte_i == 1 && !slv_skip) begin
                                ptr = rx_sh; slv_oe = 1'b1;
                            end else begin
                                mem[ptr] = rx_sh; ptr++; slv_oe = 1'b1;
                            end
                        end
                    end else if (tx) slv_oe = !tx_sh[7 - bit_i];
                end
            end
            ps = scl_o; pd = sda_bus;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr_counts();
        starts = 0; stops = 0; bytes_rx = 0; m_acks = 0; m_nacks = 0; rd_n = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 50000) begin @(negedge clk); n++; end
        if (busy) begin
            n_tests++; n_fail++;
            $display("FAIL timeout: busy actual 1 expected 0");
        end
    endtask

    task automatic do_cmd(input logic rd, input logic [6:0] dev, input logic [7:0] wa,
                          input logic [7:0] wd, input logic sk);
        @(negedge clk);
        cfg_dev_addr = dev; cfg_word_addr = wa; cfg_wr_data = wd;
        cfg_skip_word = sk; slv_skip = sk; cmd_read = rd; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_boot();
        repeat (3) @(negedge clk);
        chk("R1", "scl in reset", scl_o, 1'b1);
        chk("R1", "sda_oe in reset", sda_oe_o, 1'b0);
        chk("R1", "err in reset", err, 1'b0);
        clr_counts();
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4", "busy after reset", busy, 1'b1);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R4", "boot byte count", rd_n, 4);
        for (int i = 0; i < 4; i++)
            chk("R4", "boot byte", rd_buf[i], 8'((8'h10 + i) * 3 + 7));
        chk("R5", "master acks", m_acks, 3);
        chk("R5", "master nacks", m_nacks, 1);
        chk("R3", "boot starts", starts, 2);
        chk("R3", "boot stops", stops, 1);
        chk("R1", "released after boot", {scl_o, sda_oe_o}, 2'b10);
    endtask

    task automatic t_write();
        clr_counts();
        do_cmd(1'b0, SLV, 8'h22, 8'hA5, 1'b0);
        chk("R6", "mem after write", mem[8'h22], 8'hA5);
        chk("R6", "bytes sent", bytes_rx, 3);
        chk("R6", "no rd_valid", rd_n, 0);
        chk("R3", "write starts", starts, 1);
        chk("R3", "write stops", stops, 1);
    endtask

    task automatic t_read();
        clr_counts();
        do_cmd(1'b1, SLV, 8'h22, 8'h00, 1'b0);
        chk("R7", "read count", rd_n, 1);
        chk("R7", "read data", rd_buf[0], 8'hA5);
        chk("R7", "read nack", m_nacks, 1);
        chk("R5", "read acks", m_acks, 0);
        chk("R3", "read restart", starts, 2);
    endtask

    task automatic t_skip();
        clr_counts();
        ptr = 8'h30;
        do_cmd(1'b0, SLV, 8'hEE, 8'h5C, 1'b1);
        chk("R8", "skip write mem", mem[8'h30], 8'h5C);
        chk("R8", "skip write bytes", bytes_rx, 2);
        chk("R8", "word not used", mem[8'hEE], 8'((8'hEE * 3) + 7));
        clr_counts();
        ptr = 8'h40;
        do_cmd(1'b1, SLV, 8'hEE, 8'h00, 1'b1);
        chk("R8", "skip read data", rd_buf[0], 8'((8'h40 * 3) + 7));
        chk("R8", "skip read bytes", bytes_rx, 2);
        chk("R8", "skip read starts", starts, 2);
    endtask

    task automatic t_nack_sticky();
        clr_counts();
        do_cmd(1'b0, 7'h33, 8'h22, 8'h11, 1'b0);
        chk("R9", "err set", err, 1'b1);
        chk("R9", "busy low", busy, 1'b0);
        chk("R9", "stop issued", stops, 1);
        chk("R9", "dropped bytes", bytes_rx, 1);
        chk("R9", "mem untouched", mem[8'h22], 8'hA5);
        clr_counts();
        do_cmd(1'b0, SLV, 8'h50, 8'h3C, 1'b0);
        chk("R10", "good op done", mem[8'h50], 8'h3C);
        chk("R10", "err still set", err, 1'b1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk("R10", "err cleared", err, 1'b0);
    endtask

    task automatic t_busy_ignore();
        clr_counts();
        @(negedge clk);
        cfg_dev_addr = SLV; cfg_word_addr = 8'h60; cfg_wr_data = 8'h99;
        cfg_skip_word = 1'b0; slv_skip = 1'b0; cmd_read = 1'b0; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (100) @(negedge clk);
        cmd_read = 1'b1; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R11", "single start", starts, 1);
        chk("R11", "no read data", rd_n, 0);
        chk("R11", "busy idle", busy, 1'b0);
        chk("R11", "write done", mem[8'h60], 8'h99);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 7);
        t_reset_boot();
        t_write();
        t_read();
        t_skip();
        t_nack_sticky();
        t_busy_ignore();
        chk("R2", "scl high time violations", hi_viol, 0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule